// File: doc/BRIEF.md
# Set/Clear Aliased Flag Register

This block holds a small set of flag bits behind a simple synchronous register bus. Software never needs a read-modify-write to change one flag. A single write to the set alias turns on the chosen bits. A single write to the clear alias turns them off. Bits whose data bit is 0 keep their value in both cases, so a write from one agent cannot undo a change made by another.

The flags can be read at a read-only view offset. They are also driven continuously on a parallel output for the surrounding logic. Writes to the view offset, and writes to any unmapped offset, leave the flags alone. Read data is registered and appears one cycle after the read request.

Top module: `flag_alias_reg`

## Requirements
- R1: An active-high synchronous reset forces all flags to 0x00 and the read data to 0x00.
- R2: A write to offset 0x1 (set alias) sets every flag whose write-data bit is 1. All other flags keep their value.
- R3: A write to offset 0x2 (clear alias) clears every flag whose write-data bit is 1. All other flags keep their value.
- R4: Flag bit order is fixed. The first flag sits in bit 7 and the eighth flag in bit 0, so the sixth flag is bit 2. Writing 0x04 to either alias changes only that bit.
- R5: A write to offset 0x0 (the view), or to any offset other than 0x1 and 0x2, leaves every flag unchanged.
- R6: A read of offset 0x0 returns the flag value on the read data port one cycle after the read request. A read issued in the cycle after a write returns the updated value.
- R7: A read of offset 0x1, offset 0x2 or any unmapped offset returns 0x00.
- R8: In the cycle after a cycle with read enable low, the read data is 0x00.
- R9: The flag output port always shows the current flag value. It changes on the clock edge that accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | DATA_W (8) | Write data, one bit per flag |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | DATA_W (8) | Registered read data |
| flags_out | output | DATA_W (8) | Current flag value |

## Verification
The bench targets aliases that disturb bits outside the write mask. A design that wrote the data straight into the register, or cleared with the mask un-inverted, would change bits that should hold, and the readback after each write would be wrong. Writes to the view and to unmapped offsets are checked for no effect, which catches a decoder that treats the view as writable or ignores the upper address bits. Reads of the aliases and of idle cycles must return zero, so a design that leaked the flags through every offset, or held stale read data, fails.

// File: rtl/flag_alias_pkg.sv
package flag_alias_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_VIEW = 2'd1,
      ACC_SET  = 2'd2,
      ACC_CLR  = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/flag_alias_decode.sv
module flag_alias_decode
   import flag_alias_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int OFS_VIEW = 0,
   parameter int OFS_SET  = 1,
   parameter int OFS_CLR  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind
);
   localparam logic [ADDR_W-1:0] A_VIEW = ADDR_W'(OFS_VIEW);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

   always_comb begin
      if (addr == A_VIEW)     kind = ACC_VIEW;
      else if (addr == A_SET) kind = ACC_SET;
      else if (addr == A_CLR) kind = ACC_CLR;
      else                    kind = ACC_NONE;
   end
endmodule

// File: rtl/flag_alias_store.sv
module flag_alias_store
   import flag_alias_pkg::*;
#(
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  acc_kind_e         kind,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] flags
);
   logic do_set;
   logic do_clr;

   assign do_set = wr_en && (kind == ACC_SET);
   assign do_clr = wr_en && (kind == ACC_CLR);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic hit_set;
      logic hit_clr;
      assign hit_set = do_set & wr_data[b];
      assign hit_clr = do_clr & wr_data[b];

      always_ff @(posedge clk) begin
         if (rst)          flags[b] <= RESET_VAL[b];
         else if (hit_set) flags[b] <= 1'b1;
         else if (hit_clr) flags[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/flag_alias_rdata.sv
module flag_alias_rdata
   import flag_alias_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  acc_kind_e         kind,
   input  logic [DATA_W-1:0] flags,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (rd_en && (kind == ACC_VIEW)) rd_next = flags;
   end

   always_ff @(posedge clk) begin
      if (rst) rd_data <= '0;
      else     rd_data <= rd_next;
   end
endmodule

// File: rtl/flag_alias_reg.sv
module flag_alias_reg
   import flag_alias_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 4,
   parameter int                OFS_VIEW  = 0,
   parameter int                OFS_SET   = 1,
   parameter int                OFS_CLR   = 2,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wr_data,
   input  logic              bus_rd_en,
   output logic [DATA_W-1:0] bus_rd_data,
   output logic [DATA_W-1:0] flags_out
);
   localparam int N_OFS = 1 << ADDR_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("flag_alias_reg: DATA_W must be at least 1");
   end
   if (OFS_VIEW >= N_OFS || OFS_SET >= N_OFS || OFS_CLR >= N_OFS) begin : g_bad_ofs
      $error("flag_alias_reg: an offset does not fit in ADDR_W");
   end
   if (OFS_VIEW == OFS_SET || OFS_VIEW == OFS_CLR || OFS_SET == OFS_CLR) begin : g_dup_ofs
      $error("flag_alias_reg: offsets must be distinct");
   end

   acc_kind_e         kind;
   logic [DATA_W-1:0] flags;

   flag_alias_decode #(
      .ADDR_W(ADDR_W), .OFS_VIEW(OFS_VIEW), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
   ) u_decode (
      .addr(bus_addr),
      .kind(kind)
   );

   flag_alias_store #(
      .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)
   ) u_store (
      .clk(clk),
      .rst(rst),
      .wr_en(bus_wr_en),
      .kind(kind),
      .wr_data(bus_wr_data),
      .flags(flags)
   );

   flag_alias_rdata #(
      .DATA_W(DATA_W)
   ) u_rdata (
      .clk(clk),
      .rst(rst),
      .rd_en(bus_rd_en),
      .kind(kind),
      .flags(flags),
      .rd_data(bus_rd_data)
   );

   assign flags_out = flags;
endmodule

// File: rtl/flag_alias_chk.sv
module flag_alias_chk #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int OFS_VIEW = 0,
   parameter int OFS_SET  = 1,
   parameter int OFS_CLR  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr_en,
   input logic [DATA_W-1:0] bus_wr_data,
   input logic              bus_rd_en,
   input logic [DATA_W-1:0] bus_rd_data,
   input logic [DATA_W-1:0] flags_out
);
   localparam logic [ADDR_W-1:0] A_VIEW = ADDR_W'(OFS_VIEW);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

   AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (rst)
      (bus_wr_en && bus_addr == A_SET) |=> flags_out == ($past(flags_out) | $past(bus_wr_data))); // R2
   AST_CLR_MASKS_OUT: assert property (@(posedge clk) disable iff (rst)
      (bus_wr_en && bus_addr == A_CLR) |=> flags_out == ($past(flags_out) & ~$past(bus_wr_data))); // R3
   AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr_en && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(flags_out)); // R5
   AST_VIEW_READ: assert property (@(posedge clk) disable iff (rst)
      (bus_rd_en && bus_addr == A_VIEW) |=> bus_rd_data == $past(flags_out)); // R6
   AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      (bus_rd_en && bus_addr != A_VIEW) |=> bus_rd_data == '0); // R7
   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      !bus_rd_en |=> bus_rd_data == '0); // R8
endmodule

bind flag_alias_reg flag_alias_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_VIEW(OFS_VIEW), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
) u_chk (
   .clk(clk),
   .rst(rst),
   .bus_addr(bus_addr),
   .bus_wr_en(bus_wr_en),
   .bus_wr_data(bus_wr_data),
   .bus_rd_en(bus_rd_en),
   .bus_rd_data(bus_rd_data),
   .flags_out(flags_out)
);

// File: tb/flag_alias_reg_bench.sv
module flag_alias_reg_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] bus_addr = '0;
   logic       bus_wr_en = 1'b0;
   logic [7:0] bus_wr_data = '0;
   logic       bus_rd_en = 1'b0;
   logic [7:0] bus_rd_data;
   logic [7:0] flags_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flag_alias_reg u_flag_alias_reg (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
      .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
      .bus_rd_data(bus_rd_data), .flags_out(flags_out)
   );

   // {offset, write data, expected flags after the write}
   localparam logic [19:0] VEC [12] = '{
      {4'h1, 8'h04, 8'h04},   // R4 sixth flag set alone
      {4'h1, 8'h81, 8'h85},   // R2
      {4'h2, 8'h04, 8'h81},   // R4 sixth flag cleared alone
      {4'h0, 8'hFF, 8'h81},   // R5 view write ignored
      {4'h7, 8'h7E, 8'h81},   // R5 unmapped write ignored
      {4'h1, 8'hF0, 8'hF1},   // R2
      {4'h2, 8'h0F, 8'hF0},   // R3
      {4'h2, 8'h00, 8'hF0},   // R3 empty mask
      {4'h1, 8'h00, 8'hF0},   // R2 empty mask
      {4'h1, 8'hFF, 8'hFF},   // R2 all bits
      {4'h2, 8'hA5, 8'h5A},   // R3
      {4'hF, 8'h00, 8'h5A}    // R5 top offset
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      @(negedge clk);
      bus_rd_en = 1'b0;
      d = bus_rd_data;
   endtask

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 flags after reset", flags_out, 8'h00);
      chk("R1 read data after reset", bus_rd_data, 8'h00);

      for (int i = 0; i < 12; i++) begin
         logic [3:0] a;
         logic [7:0] d;
         logic [7:0] e;
         string tag;
         {a, d, e} = VEC[i];
         tag = (a == 4'h1) ? "R2/R4" : (a == 4'h2) ? "R3/R4" : "R5";
         bus_write(a, d);
         chk({tag, " R9 flag output"}, flags_out, e);
         bus_read(4'h0, rd);
         chk({tag, " R6 readback"}, rd, e);
      end

      // R7 alias and unmapped reads return zero while flags are 0x5A
      bus_read(4'h1, rd);
      chk("R7 set alias read", rd, 8'h00);
      bus_read(4'h2, rd);
      chk("R7 clear alias read", rd, 8'h00);
      bus_read(4'h3, rd);
      chk("R7 unmapped read", rd, 8'h00);

      // R8 idle cycle after a view read
      bus_read(4'h0, rd);
      chk("R6 view read", rd, 8'h5A);
      @(negedge clk);
      chk("R8 idle read data", bus_rd_data, 8'h00);

      // R6 back-to-back write then read
      bus_write(4'h1, 8'h01);
      bus_read(4'h0, rd);
      chk("R6 read right after write", rd, 8'h5B);

      // R1 mid-run reset clears nonzero flags
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 flags after mid-run reset", flags_out, 8'h00);
      bus_read(4'h0, rd);
      chk("R1 readback after mid-run reset", rd, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule